// File: doc/BRIEF.md
# Serial Sensor Bus Frame Engine

This block is the master side of one channel of a serial sensor bus. A host loads a command word as two bytes and releases it with a chip-select rising edge. The engine then runs one frame on three internal lines: an active-low frame strobe, a transmit line that carries each bit as the width of a low pulse, and a return line that the sensor drives.

Every frame begins with one idle bit time. The data bits follow, most significant first, and then a CRC that the engine computes over them. While the engine transmits, it samples the return line once per bit and shifts the reply in. It recomputes the CRC over the received data bits and compares it with the received CRC bits. A mismatch raises an error flag and zeroes the reported data.

The engine also enforces a minimum gap between frames, counted in bit times. It keeps a command-empty flag and a reply-ready flag, and a sticky overrun bit that records any write the engine had to ignore.

Top module: `sbus_frame_engine`

## Requirements
- R1: One bit time is 3*SUB_CLKS clock cycles. `frame_n` stays low for exactly (1 + cfg_dlen + cfg_clen) bit times and rises at the end of the last CRC bit, or at the end of the last data bit when cfg_clen is 0.
- R2: During the first bit time of a frame, `tx_line` stays high. The next cfg_dlen bits carry the command word from bit cfg_dlen-1 down to bit 0.
- R3: Each bit after the first starts with `tx_line` falling. The line stays low for SUB_CLKS cycles to send a 1, or for 2*SUB_CLKS cycles to send a 0, and is high for the rest of the bit.
- R4: Straight after the data bits, the engine sends cfg_clen CRC bits, most significant first. The CRC starts from zero. Each data bit d is folded in as follows: f = d xor c[L-1]; c = (c shifted left by one, kept to L bits) xor (f ? POLY[L-1:0] : 0), where L = cfg_clen. When cfg_clen is 0, no CRC bits are sent.
- R5: In the last clock cycle of each data bit, the engine samples `ret_line`. When the frame ends, the received data appears in the low cfg_dlen bits of `rx_data`, most significant bit received first, with zeros above.
- R6: The engine recomputes the CRC of R4 over the received data bits and compares it with the received CRC bits. If any bit differs, `rx_err` is 1 and `rx_data` is all zeros.
- R7: Writing with `wr_hi`=1 stores the high byte. Writing with `wr_hi`=0 stores the low byte and fills the command register, so `te` falls. The value sent is the low cfg_dlen bits of high:low. `te` rises again in the cycle that `frame_n` falls.
- R8: A filled command launches only after a rising edge of `cs_n` with `ferr` low at that edge. If `ferr` is high at that edge, the command is discarded, `te` returns to 1 and no frame starts.
- R9: After `frame_n` rises, at least cfg_gap bit times pass before it falls again. If a command is already armed, `frame_n` stays high for exactly cfg_gap*3*SUB_CLKS + 1 cycles.
- R10: A write while `te` is 0 has no effect on the command, and it sets `overrun`. `overrun` stays set until reset.
- R11: `rne` rises in the cycle that `frame_n` rises. A one-cycle `rd_en` pulse clears it.
- R12: After reset, `frame_n`, `tx_line` and `te` are 1, and `rne`, `overrun` and `rx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte (completes the command) |
| wr_byte | input | 8 | Byte being written |
| cs_n | input | 1 | Host chip select; its rising edge releases the command |
| ferr | input | 1 | Host framing error, sampled at the chip-select rising edge |
| rd_en | input | 1 | Host acknowledges the reply; clears `rne` |
| cfg_dlen | input | 5 | Number of data bits, 1 to DATA_MAX |
| cfg_clen | input | 3 | Number of CRC bits, 0 to CRC_MAX |
| cfg_gap | input | 8 | Minimum inter-frame gap in bit times |
| ret_line | input | 1 | Return line from the sensor |
| frame_n | output | 1 | Frame strobe, low during a frame |
| tx_line | output | 1 | Pulse-width-coded transmit line |
| te | output | 1 | Command register empty |
| rne | output | 1 | Reply ready |
| overrun | output | 1 | Sticky flag for an ignored write |
| rx_data | output | 16 | Received data, zeroed on a CRC error |
| rx_err | output | 1 | CRC error on the last reply |

## Verification
The bench builds the engine with SUB_CLKS=1, so a bit is only three cycles long. It keeps DATA_MAX=16, CRC_MAX=4 and POLY=4'h3. At that bit length the bench can sweep every data length against every CRC length, with both a clean and a corrupted reply, and then run all 256 command values at 8 data bits. Every pulse width is decoded cycle by cycle. Gap values of 6 and 9 bit times give high periods short enough to measure exactly.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    LNK_IDLE = 1'b0,
    LNK_RUN  = 1'b1
  } lnk_state_e;
endpackage

// File: rtl/sbus_bit_clock.sv
module sbus_bit_clock #(
  parameter int SUB_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  output logic [1:0] third,
  output logic       bit_end
);
  localparam int SUB_W = (SUB_CLKS > 1) ? $clog2(SUB_CLKS) : 1;

  logic [SUB_W-1:0] sub_q, sub_n;
  logic [1:0]       third_q, third_n;
  logic             sub_wrap;

  assign sub_wrap = (sub_q == SUB_W'(SUB_CLKS - 1));
  assign third    = third_q;
  assign bit_end  = sub_wrap && (third_q == 2'd2);

  always_comb begin
    sub_n   = sub_q;
    third_n = third_q;
    if (restart) begin
      sub_n   = '0;
      third_n = 2'd0;
    end else if (sub_wrap) begin
      sub_n   = '0;
      third_n = (third_q == 2'd2) ? 2'd0 : third_q + 2'd1;
    end else begin
      sub_n = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      third_q <= 2'd0;
    end else begin
      sub_q   <= sub_n;
      third_q <= third_n;
    end
  end
endmodule

// File: rtl/sbus_cmd_reg.sv
module sbus_cmd_reg
  import sbus_pkg::*;
#(
  parameter int DATA_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_byte,
  input  logic                cs_n,
  input  logic                ferr,
  input  logic                take,
  output logic [DATA_MAX-1:0] cmd_word,
  output logic                ready,
  output logic                te,
  output logic                overrun
);
  logic [BYTE_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic              full_q, full_n, armed_q, armed_n;
  logic              ovr_q, ovr_n, cs_q;
  logic              cs_rise;
  logic [WORD_W-1:0] both;

  assign cs_rise  = cs_n && !cs_q;
  assign both     = {hi_q, lo_q};
  assign cmd_word = both[DATA_MAX-1:0];
  assign ready    = full_q && armed_q;
  assign te       = !full_q;
  assign overrun  = ovr_q;

  always_comb begin
    hi_n    = hi_q;
    lo_n    = lo_q;
    full_n  = full_q;
    armed_n = armed_q;
    ovr_n   = ovr_q;
    if (take) begin
      full_n  = 1'b0;
      armed_n = 1'b0;
    end else if (cs_rise && full_q && !armed_q) begin
      if (ferr) full_n  = 1'b0;
      else      armed_n = 1'b1;
    end
    if (wr_en) begin
      if (full_q) begin
        ovr_n = 1'b1;
      end else if (wr_hi) begin
        hi_n = wr_byte;
      end else begin
        lo_n   = wr_byte;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      full_q  <= 1'b0;
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      full_q  <= full_n;
      armed_q <= armed_n;
      ovr_q   <= ovr_n;
      cs_q    <= cs_n;
    end
  end

  assert_sticky_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovr_q) |-> ovr_q);
  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !te) |=> $stable(cmd_word));
endmodule

// File: rtl/sbus_link.sv
module sbus_link
  import sbus_pkg::*;
#(
  parameter int                      DATA_MAX = 16,
  parameter int                      CRC_MAX  = 4,
  parameter logic [CRC_MAX-1:0]      POLY     = 4'h3,
  localparam int                     DL_W     = $clog2(DATA_MAX + 1),
  localparam int                     CL_W     = $clog2(CRC_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DATA_MAX-1:0] cmd_word,
  input  logic [DL_W-1:0]     cfg_dlen,
  input  logic [CL_W-1:0]     cfg_clen,
  input  logic [1:0]          third,
  input  logic                bit_end,
  input  logic                ret_line,
  output logic                busy,
  output logic                frame_n,
  output logic                tx_line,
  output logic                done,
  output logic [DATA_MAX-1:0] res_data,
  output logic                res_err
);
  localparam int SLOT_W = $clog2(DATA_MAX + CRC_MAX + 2);

  lnk_state_e          st_q, st_n;
  logic [SLOT_W-1:0]   slot_q, slot_n;
  logic [DL_W-1:0]     dl_q, dl_n;
  logic [CL_W-1:0]     cl_q, cl_n;
  logic [DATA_MAX-1:0] txsh_q, txsh_n, rxsh_q, rxsh_n;
  logic [CRC_MAX-1:0]  ctx_q, ctx_n, crx_q, crx_n, pal_q, pal_n;
  logic                err_q, err_n;
  logic                in_data, in_crc, last, cur_bit, run, tx_low;

  function automatic logic [CRC_MAX-1:0] crc_step(input logic [CRC_MAX-1:0] c,
                                                  input logic b,
                                                  input logic [CRC_MAX-1:0] p);
    crc_step = (c << 1) ^ ((b ^ c[CRC_MAX-1]) ? p : '0);
  endfunction

  assign run     = (st_q == LNK_RUN);
  assign in_data = (slot_q != '0) && (slot_q <= SLOT_W'(dl_q));
  assign in_crc  = (slot_q > SLOT_W'(dl_q));
  assign last    = (slot_q == SLOT_W'(dl_q) + SLOT_W'(cl_q));
  assign cur_bit = in_data ? txsh_q[DATA_MAX-1] : ctx_q[CRC_MAX-1];
  assign tx_low  = run && (slot_q != '0) &&
                   ((third == 2'd0) || ((third == 2'd1) && !cur_bit));
  assign tx_line = !tx_low;
  assign frame_n = !run;
  assign busy    = run;
  assign done    = run && bit_end && last;
  assign res_data = rxsh_n;
  assign res_err  = err_n;

  always_comb begin
    st_n   = st_q;
    slot_n = slot_q;
    dl_n   = dl_q;
    cl_n   = cl_q;
    txsh_n = txsh_q;
    rxsh_n = rxsh_q;
    ctx_n  = ctx_q;
    crx_n  = crx_q;
    pal_n  = pal_q;
    err_n  = err_q;
    if (!run) begin
      if (start) begin
        st_n   = LNK_RUN;
        slot_n = '0;
        dl_n   = cfg_dlen;
        cl_n   = cfg_clen;
        txsh_n = cmd_word << (DL_W'(DATA_MAX) - cfg_dlen);
        rxsh_n = '0;
        ctx_n  = '0;
        crx_n  = '0;
        pal_n  = POLY << (CL_W'(CRC_MAX) - cfg_clen);
        err_n  = 1'b0;
      end
    end else if (bit_end) begin
      if (in_data) begin
        txsh_n = txsh_q << 1;
        ctx_n  = crc_step(ctx_q, cur_bit, pal_q);
        rxsh_n = {rxsh_q[DATA_MAX-2:0], ret_line};
        crx_n  = crc_step(crx_q, ret_line, pal_q);
      end else if (in_crc) begin
        ctx_n = ctx_q << 1;
        err_n = err_q | (ret_line ^ crx_q[CRC_MAX-1]);
        crx_n = crx_q << 1;
      end
      if (last) st_n = LNK_IDLE;
      else      slot_n = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LNK_IDLE;
      slot_q <= '0;
      dl_q   <= '0;
      cl_q   <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      ctx_q  <= '0;
      crx_q  <= '0;
      pal_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      slot_q <= slot_n;
      dl_q   <= dl_n;
      cl_q   <= cl_n;
      txsh_q <= txsh_n;
      rxsh_q <= rxsh_n;
      ctx_q  <= ctx_n;
      crx_q  <= crx_n;
      pal_q  <= pal_n;
      err_q  <= err_n;
    end
  end

  assert_pulse_starts_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_line) |-> (third == 2'd0));
  assert_frame_ends_on_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> $past(bit_end));
endmodule

// File: rtl/sbus_frame_engine.sv
module sbus_frame_engine
  import sbus_pkg::*;
#(
  parameter int                 DATA_MAX = 16,
  parameter int                 CRC_MAX  = 4,
  parameter logic [CRC_MAX-1:0] POLY     = 4'h3,
  parameter int                 SUB_CLKS = 16,
  parameter int                 GAP_W    = 8,
  localparam int                DL_W     = $clog2(DATA_MAX + 1),
  localparam int                CL_W     = $clog2(CRC_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_byte,
  input  logic                cs_n,
  input  logic                ferr,
  input  logic                rd_en,
  input  logic [DL_W-1:0]     cfg_dlen,
  input  logic [CL_W-1:0]     cfg_clen,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                ret_line,
  output logic                frame_n,
  output logic                tx_line,
  output logic                te,
  output logic                rne,
  output logic                overrun,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_err
);
  logic [1:0]          rst_sync_q;
  logic                rst_s_n;
  logic [DATA_MAX-1:0] cmd_word, res_data;
  logic                ready, busy, done, res_err, start, bit_end, gap_ok;
  logic [1:0]          third;
  logic [GAP_W-1:0]    gap_q, gap_n;
  logic                rne_q, rne_n, err_q, err_n;
  logic [DATA_MAX-1:0] dat_q, dat_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign gap_ok = (gap_q >= cfg_gap);
  assign start  = !busy && ready && gap_ok;

  sbus_cmd_reg #(.DATA_MAX(DATA_MAX)) u_cmd (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_byte(wr_byte),
    .cs_n(cs_n), .ferr(ferr), .take(start), .cmd_word(cmd_word), .ready(ready),
    .te(te), .overrun(overrun));

  sbus_bit_clock #(.SUB_CLKS(SUB_CLKS)) u_bclk (
    .clk(clk), .rst_n(rst_s_n), .restart(start || done), .third(third),
    .bit_end(bit_end));

  sbus_link #(.DATA_MAX(DATA_MAX), .CRC_MAX(CRC_MAX), .POLY(POLY)) u_link (
    .clk(clk), .rst_n(rst_s_n), .start(start), .cmd_word(cmd_word),
    .cfg_dlen(cfg_dlen), .cfg_clen(cfg_clen), .third(third), .bit_end(bit_end),
    .ret_line(ret_line), .busy(busy), .frame_n(frame_n), .tx_line(tx_line),
    .done(done), .res_data(res_data), .res_err(res_err));

  always_comb begin
    gap_n = gap_q;
    rne_n = rne_q;
    err_n = err_q;
    dat_n = dat_q;
    if (done) begin
      gap_n = '0;
      rne_n = 1'b1;
      err_n = res_err;
      dat_n = res_err ? '0 : res_data;
    end else begin
      if (!busy && bit_end && (gap_q != {GAP_W{1'b1}})) gap_n = gap_q + 1'b1;
      if (rd_en) rne_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gap_q <= {GAP_W{1'b1}};
      rne_q <= 1'b0;
      err_q <= 1'b0;
      dat_q <= '0;
    end else begin
      gap_q <= gap_n;
      rne_q <= rne_n;
      err_q <= err_n;
      dat_q <= dat_n;
    end
  end

  assign rne     = rne_q;
  assign rx_err  = err_q;
  assign rx_data = dat_q;

  assert_gap_before_launch_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(frame_n) |-> $past(gap_ok));
  assert_launch_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(frame_n) |-> $past(ready));
  assert_launch_frees_cmd_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(frame_n) |-> te);
  assert_rne_at_frame_end_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rne) |-> $rose(frame_n));
  assert_zero_on_err_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    rx_err |-> (rx_data == '0));
endmodule

// File: tb/sim_sbus_frame_engine.sv
module sim_sbus_frame_engine;
  localparam int SUB = 1;
  localparam int BIT = 3 * SUB;
  localparam logic [3:0] POLY = 4'h3;

  logic clk, rst_n, wr_en, wr_hi, cs_n, ferr, rd_en, ret_line;
  logic [7:0]  wr_byte, cfg_gap;
  logic [4:0]  cfg_dlen;
  logic [2:0]  cfg_clen;
  logic        frame_n, tx_line, te, rne, overrun, rx_err;
  logic [15:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  int hi_run = 0;
  int last_hi = 0;
  logic [31:0] seed = 32'h1234_5678;

  sbus_frame_engine #(.DATA_MAX(16), .CRC_MAX(4), .POLY(POLY), .SUB_CLKS(SUB),
                      .GAP_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_byte(wr_byte),
    .cs_n(cs_n), .ferr(ferr), .rd_en(rd_en), .cfg_dlen(cfg_dlen),
    .cfg_clen(cfg_clen), .cfg_gap(cfg_gap), .ret_line(ret_line),
    .frame_n(frame_n), .tx_line(tx_line), .te(te), .rne(rne),
    .overrun(overrun), .rx_data(rx_data), .rx_err(rx_err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (frame_n === 1'b1) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:16];
  endfunction

  function automatic logic [3:0] crc_model(input logic [15:0] d, input int dl, input int cl);
    logic [3:0] c, m;
    logic fb;
    c = '0;
    if (cl == 0) return '0;
    m = 4'((1 << cl) - 1);
    for (int i = dl - 1; i >= 0; i--) begin
      fb = d[i] ^ c[cl-1];
      c = (c << 1) & m;
      if (fb) c = c ^ (POLY & m);
    end
    return c;
  endfunction

  task automatic host_load(input logic [15:0] w);
    @(negedge clk); wr_en = 1'b1; wr_hi = 1'b1; wr_byte = w[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_byte = w[7:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_cs(input bit fe);
    @(negedge clk); cs_n = 1'b0; ferr = fe;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); ferr = 1'b0;
  endtask

  task automatic read_out();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(rne == 1'b0, "R11 rne cleared by read", rne, 0);
  endtask

  task automatic run_frame(input logic [15:0] cmd, input int dl, input int cl,
                           input logic [15:0] resp, input bit corrupt);
    bit txb[0:31];
    bit rxb[0:31];
    logic [3:0] ct, cr;
    int total, w, lows;
    bit wave_ok, shape_ok, pre_ok, data_ok, crc_ok, exp_err, exp_lvl;
    logic [15:0] exp_data, dmask;
    total = 1 + dl + cl;
    ct = crc_model(cmd, dl, cl);
    cr = crc_model(resp, dl, cl);
    if (corrupt && cl > 0) cr[0] = ~cr[0];
    txb[0] = 1'b1;
    rxb[0] = 1'b1;
    for (int i = 0; i < dl; i++) begin
      txb[1+i] = cmd[dl-1-i];
      rxb[1+i] = resp[dl-1-i];
    end
    for (int i = 0; i < cl; i++) begin
      txb[1+dl+i] = ct[cl-1-i];
      rxb[1+dl+i] = cr[cl-1-i];
    end
    w = 0;
    while (frame_n && w < 80) begin @(negedge clk); w++; end
    chk(frame_n == 1'b0, "R8 frame launched after cs rise", frame_n, 0);
    if (frame_n) return;
    chk(te == 1'b1, "R7 te high once frame starts", te, 1);
    wave_ok = 1; shape_ok = 1; pre_ok = 1; data_ok = 1; crc_ok = 1;
    for (int s = 0; s < total; s++) begin
      lows = 0;
      for (int p = 0; p < BIT; p++) begin
        if (frame_n !== 1'b0) wave_ok = 0;
        ret_line = rxb[s];
        if (tx_line === 1'b0) lows++;
        exp_lvl = !(s > 0 && p < (txb[s] ? SUB : 2 * SUB));
        if (tx_line !== exp_lvl) shape_ok = 0;
        @(negedge clk);
      end
      if (s == 0) begin
        if (lows != 0) pre_ok = 0;
      end else if (lows != (txb[s] ? SUB : 2 * SUB)) begin
        if (s <= dl) data_ok = 0;
        else crc_ok = 0;
      end
    end
    ret_line = 1'b1;
    chk(wave_ok, "R1 strobe low for whole frame", wave_ok, 1);
    chk(frame_n == 1'b1, "R1 strobe high after last bit", frame_n, 1);
    chk(shape_ok, "R3 pulse widths", shape_ok, 1);
    chk(pre_ok, "R2 first bit time idle", pre_ok, 1);
    chk(data_ok, "R2 data bits msb first", data_ok, 1);
    chk(crc_ok, "R4 crc bits", crc_ok, 1);
    chk(rne == 1'b1, "R11 rne set at frame end", rne, 1);
    exp_err = corrupt && (cl > 0);
    dmask = 16'((32'h1 << dl) - 1);
    exp_data = exp_err ? 16'h0 : (resp & dmask);
    chk(rx_err == exp_err, "R6 crc error flag", rx_err, exp_err);
    chk(rx_data == exp_data, exp_err ? "R6 data zeroed" : "R5 received data",
        rx_data, exp_data);
  endtask

  task automatic xfer(input logic [15:0] cmd, input int dl, input int cl,
                      input logic [15:0] resp, input bit corrupt);
    cfg_dlen = 5'(dl);
    cfg_clen = 3'(cl);
    host_load(cmd);
    chk(te == 1'b0, "R7 te low once loaded", te, 0);
    pulse_cs(1'b0);
    run_frame(cmd, dl, cl, resp, corrupt);
    read_out();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    bit ok;
    rst_n = 1'b0; wr_en = 0; wr_hi = 0; wr_byte = 0; cs_n = 1; ferr = 0; rd_en = 0;
    ret_line = 1; cfg_dlen = 5'd8; cfg_clen = 3'd4; cfg_gap = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(frame_n == 1 && tx_line == 1, "R12 lines idle after reset", {frame_n, tx_line}, 3);
    chk(te == 1 && rne == 0, "R12 flags after reset", {te, rne}, 2);
    chk(overrun == 0 && rx_err == 0, "R12 overrun and error clear", {overrun, rx_err}, 0);

    for (int dl = 1; dl <= 16; dl++)
      for (int cl = 0; cl <= 4; cl++)
        for (int pat = 0; pat < 2; pat++) begin
          a = rnd();
          b = rnd();
          xfer(a, dl, cl, b, pat == 1);
        end

    for (int v = 0; v < 256; v++)
      xfer({8'(v) ^ 8'h5a, 8'(v)}, 8, 3, {8'h00, ~8'(v)}, (v % 5) == 0);

    // R10: second load while full is ignored
    chk(overrun == 1'b0, "R10 overrun clear before", overrun, 0);
    cfg_dlen = 5'd12; cfg_clen = 3'd4;
    host_load(16'h0abc);
    host_load(16'h0123);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    chk(te == 1'b0, "R10 te still low", te, 0);
    pulse_cs(1'b0);
    run_frame(16'h0abc, 12, 4, 16'h0f0f, 1'b0);
    read_out();
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

    // R8: framing error drops the command
    cfg_dlen = 5'd10; cfg_clen = 3'd2;
    host_load(16'h02aa);
    pulse_cs(1'b1);
    repeat (2) @(negedge clk);
    chk(te == 1'b1, "R8 command dropped on framing error", te, 1);
    ok = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!frame_n) ok = 0; end
    chk(ok, "R8 no frame after framing error", ok, 1);

    // R8: no frame until chip-select rises
    host_load(16'h0355);
    ok = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!frame_n) ok = 0; end
    chk(ok, "R8 no frame without cs rise", ok, 1);
    chk(te == 1'b0, "R8 command still held", te, 0);
    pulse_cs(1'b0);
    run_frame(16'h0355, 10, 2, 16'h0123, 1'b0);
    read_out();

    // R9: exact inter-frame gap
    for (int g = 6; g <= 9; g += 3) begin
      cfg_gap = 8'(g);
      cfg_dlen = 5'd5; cfg_clen = 3'd2;
      host_load(16'h0015);
      pulse_cs(1'b0);
      run_frame(16'h0015, 5, 2, 16'h000a, 1'b0);
      host_load(16'h000b);
      pulse_cs(1'b0);
      run_frame(16'h000b, 5, 2, 16'h0011, 1'b1);
      chk(last_hi == g * BIT + 1, "R9 gap high time", last_hi, g * BIT + 1);
      read_out();
    end
    cfg_gap = 8'd0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule